// File: doc/BRIEF.md
# Byte-Lane Parity Unit

This unit sits on one 36-bit data port. It treats the word as four 9-bit lanes. Bits 0-8, 9-17, 18-26 and 27-35 each form a lane, and the top bit of each lane is that lane's parity bit. It checks the parity of whatever is applied to the port's input bus and pulls an active-low error flag when any lane breaks the chosen parity. The `odd_sel` input chooses the parity type.

On reads it can replace each lane's top bit with a parity bit computed from the lane's lower eight bits. It does this on two paths:
- **FIFO path.** The word from memory passes through the generator and is then captured in an output register. This happens on the clock edge that performs the read.
- **Mailbox path.** Generation is purely combinational, and the stored mailbox word is never altered.

The same parity tree serves both checking and mailbox generation. For that reason the error flag is held high while a mailbox read with generation is selected. Words presented for writing leave the unit exactly as they arrived. Storage and clock crossing belong to the surrounding port logic.

Top module: `lane_parity_port`

## Requirements
- R1: With `odd_sel` low (even parity), a lane passes when its nine bits hold an even number of ones. `perr_n` is low when any lane fails and high when all four pass, while no generating mailbox read is selected.
- R2: With `odd_sel` high (odd parity), a lane passes when its nine bits hold an odd number of ones, and `perr_n` follows the same rule as R1.
- R3: `perr_n` is high, whatever `bus_in` holds, while a generating mailbox read is selected. That selection is `cs_n`=0, `xfer_en`=1, `wr_sel`=0, `mbox_sel`=1 and `gen_en`=1.
- R4: If any single one of the R3 conditions is missing, `perr_n` reports the lane check of R1/R2 as usual.
- R5: A FIFO read is `cs_n`=0, `xfer_en`=1, `wr_sel`=0 and `mbox_sel`=0. It loads `fifo_out` on that rising edge:
  - with `gen_en` low, `fifo_out` takes `fifo_rd_data` unchanged;
  - with `gen_en` high, `fifo_out` takes `fifo_rd_data` with bits 8, 17, 26 and 35 replaced by parity computed from each lane's bits 0-7 under `odd_sel`;
  - `gen_en` and `odd_sel` are sampled at that edge only.
- R6: `fifo_out` holds its value on every edge that is not a FIFO read, including write cycles and idle cycles.
- R7: `mbox_out` equals `mbox_data` while `gen_en` is low. While `gen_en` is high it is `mbox_data` with the lane top bits regenerated as in R5, combinationally from the current `odd_sel`.
- R8: `store_en` is high exactly when `cs_n`=0, `xfer_en`=1 and `wr_sel`=1. `store_data` always equals `bus_in` bit for bit, whatever `gen_en` is.
- R9: While `rst_n` is low, `fifo_out` is all zeros.
- R10: `port_out` shows `mbox_out` when `mbox_sel` is high and `fifo_out` when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Port select, active low |
| xfer_en | input | 1 | Transfer enable, active high |
| wr_sel | input | 1 | 1 = write, 0 = read |
| mbox_sel | input | 1 | 1 = mailbox, 0 = FIFO |
| gen_en | input | 1 | Parity generation on reads |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| bus_in | input | 36 | Word applied to the port inputs |
| fifo_rd_data | input | 36 | Word read from FIFO memory |
| mbox_data | input | 36 | Current mailbox register contents |
| store_en | output | 1 | A write is selected this cycle |
| store_data | output | 36 | Word to store, unchanged from the bus |
| fifo_out | output | 36 | FIFO output register |
| mbox_out | output | 36 | Mailbox word, parity regenerated when enabled |
| port_out | output | 36 | Word driven towards the port |
| perr_n | output | 1 | Parity error flag, active low |

## Verification
The bench builds the unit at its default of four lanes of nine bits. This keeps every lane boundary, meaning bits 8, 17, 26 and 35, reachable with single-bit patterns, so a bit fault in one lane can be isolated from its neighbours. With that width the bench covers:
- both parity senses on the checker and the generator;
- the masking of the error flag, with each of its five enabling conditions removed in turn;
- the sampling of `gen_en` at the loading edge, by changing it immediately after that edge.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;
  localparam int unsigned LP_LANE_W = 9;
  localparam int unsigned LP_DATA_W = LP_LANE_W - 1;

  // Parity bit that completes a lane: even -> XOR of data, odd -> inverted.
  function automatic logic lp_gen_bit(input logic [LP_DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // A lane fails when its full XOR disagrees with the selected sense.
  function automatic logic lp_lane_bad(input logic [LP_LANE_W-1:0] lane, input logic odd);
    return (^lane) ^ odd;
  endfunction
endpackage

// File: rtl/lp_lane_check.sv
module lp_lane_check #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES*lane_parity_pkg::LP_LANE_W-1:0] word,
  input  logic                                         odd,
  output logic [LANES-1:0]                             lane_fail
);
  import lane_parity_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_fail[g] = lp_lane_bad(word[g*LP_LANE_W +: LP_LANE_W], odd);
  end
endmodule

// File: rtl/lp_lane_gen.sv
module lp_lane_gen #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES*lane_parity_pkg::LP_LANE_W-1:0] word_in,
  input  logic                                         odd,
  input  logic                                         enable,
  output logic [LANES*lane_parity_pkg::LP_LANE_W-1:0] word_out
);
  import lane_parity_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned BASE = g * LP_LANE_W;
    logic [LP_DATA_W-1:0] data;
    assign data = word_in[BASE +: LP_DATA_W];
    assign word_out[BASE +: LP_DATA_W] = data;
    assign word_out[BASE + LP_DATA_W] = enable ? lp_gen_bit(data, odd)
                                               : word_in[BASE + LP_DATA_W];
  end
endmodule

// File: rtl/lp_out_reg.sv
module lp_out_reg #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/lane_parity_port.sv
module lane_parity_port #(
  parameter int unsigned LANES = 4,
  localparam int unsigned W = LANES * lane_parity_pkg::LP_LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         xfer_en,
  input  logic         wr_sel,
  input  logic         mbox_sel,
  input  logic         gen_en,
  input  logic         odd_sel,
  input  logic [W-1:0] bus_in,
  input  logic [W-1:0] fifo_rd_data,
  input  logic [W-1:0] mbox_data,
  output logic         store_en,
  output logic [W-1:0] store_data,
  output logic [W-1:0] fifo_out,
  output logic [W-1:0] mbox_out,
  output logic [W-1:0] port_out,
  output logic         perr_n
);
  // Decoded port events, brought out as named wires for the checker.
  logic             active;
  logic             rd_sel;
  logic             fifo_rd;
  logic             mbox_gen_rd;
  logic [LANES-1:0] lane_fail;
  logic [W-1:0]     fifo_gen;

  assign active      = !cs_n && xfer_en;
  assign rd_sel      = active && !wr_sel;
  assign fifo_rd     = rd_sel && !mbox_sel;
  assign mbox_gen_rd = rd_sel && mbox_sel && gen_en;
  assign store_en    = active && wr_sel;
  assign store_data  = bus_in;

  lp_lane_check #(.LANES(LANES)) u_check (
    .word      (bus_in),
    .odd       (odd_sel),
    .lane_fail (lane_fail)
  );

  // Shared tree: a generating mailbox read masks the check result.
  assign perr_n = mbox_gen_rd ? 1'b1 : ~|lane_fail;

  lp_lane_gen #(.LANES(LANES)) u_gen_fifo (
    .word_in  (fifo_rd_data),
    .odd      (odd_sel),
    .enable   (gen_en),
    .word_out (fifo_gen)
  );

  lp_out_reg #(.W(W)) u_out_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fifo_rd),
    .d     (fifo_gen),
    .q     (fifo_out)
  );

  lp_lane_gen #(.LANES(LANES)) u_gen_mbox (
    .word_in  (mbox_data),
    .odd      (odd_sel),
    .enable   (gen_en),
    .word_out (mbox_out)
  );

  assign port_out = mbox_sel ? mbox_out : fifo_out;
endmodule

// File: rtl/lane_parity_port_chk.sv
module lane_parity_port_chk #(
  parameter int unsigned LANES = 4,
  localparam int unsigned W = LANES * 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic         odd_sel,
  input logic         gen_en,
  input logic [W-1:0] fifo_rd_data,
  input logic [W-1:0] mbox_data,
  input logic [W-1:0] fifo_out,
  input logic [W-1:0] mbox_out,
  input logic         perr_n,
  input logic         fifo_rd,
  input logic         mbox_gen_rd
);
  function automatic logic all_lanes_ok(input logic [W-1:0] w, input logic odd);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (($countones(w[i*9 +: 9]) % 2 == 1) != odd) ok = 1'b0;
    return ok;
  endfunction

  AST_MASK_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_gen_rd |-> perr_n); // R3

  AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_rd |=> $stable(fifo_out)); // R6

  AST_FIFO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !gen_en) |=> fifo_out == $past(fifo_rd_data)); // R5

  AST_FIFO_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && gen_en) |=> all_lanes_ok(fifo_out, $past(odd_sel))); // R5

  AST_MBOX_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> mbox_out == mbox_data); // R7

  AST_MBOX_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en |-> all_lanes_ok(mbox_out, odd_sel)); // R7
endmodule

bind lane_parity_port lane_parity_port_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .odd_sel      (odd_sel),
  .gen_en       (gen_en),
  .fifo_rd_data (fifo_rd_data),
  .mbox_data    (mbox_data),
  .fifo_out     (fifo_out),
  .mbox_out     (mbox_out),
  .perr_n       (perr_n),
  .fifo_rd      (fifo_rd),
  .mbox_gen_rd  (mbox_gen_rd)
);

// File: tb/test_lane_parity_port.sv
module test_lane_parity_port;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1, xfer_en = 1'b0, wr_sel = 1'b0, mbox_sel = 1'b0;
  logic         gen_en = 1'b0, odd_sel = 1'b0;
  logic [W-1:0] bus_in = '0, fifo_rd_data = '0, mbox_data = '0;
  logic         store_en, perr_n;
  logic [W-1:0] store_data, fifo_out, mbox_out, port_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_parity_port i_lane_parity_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .xfer_en(xfer_en), .wr_sel(wr_sel),
    .mbox_sel(mbox_sel), .gen_en(gen_en), .odd_sel(odd_sel), .bus_in(bus_in),
    .fifo_rd_data(fifo_rd_data), .mbox_data(mbox_data), .store_en(store_en),
    .store_data(store_data), .fifo_out(fifo_out), .mbox_out(mbox_out),
    .port_out(port_out), .perr_n(perr_n)
  );

  // Expected flag: high only when every lane meets the selected sense.
  function automatic logic exp_flag(input logic [W-1:0] w, input logic odd);
    for (int i = 0; i < 4; i++)
      if (($countones(w[i*9 +: 9]) & 1) != int'(odd)) return 1'b0;
    return 1'b1;
  endfunction

  // Expected regenerated word: top bit set so each lane count matches.
  function automatic logic [W-1:0] exp_gen(input logic [W-1:0] w, input logic odd);
    logic [W-1:0] r;
    r = w;
    for (int i = 0; i < 4; i++) begin
      int c;
      c = $countones(w[i*9 +: 8]);
      r[i*9 + 8] = odd ? (c % 2 == 0) : (c % 2 == 1);
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; xfer_en = 1'b0; wr_sel = 1'b0; mbox_sel = 1'b0; gen_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "fifo_out in reset", fifo_out, '0);
    chk("R10", "port_out in reset", port_out, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_even();
    logic [W-1:0] pats [4];
    pats[0] = 36'h0;
    pats[1] = 36'h0_0000_0100;  // lane 0 parity bit alone
    pats[2] = 36'h0_0400_0000;  // single one in lane 2
    pats[3] = 36'h8_0600_0003;
    idle(); odd_sel = 1'b0;
    foreach (pats[i]) begin
      @(negedge clk); bus_in = pats[i]; #1;
      chk("R1", "even check", {35'd0, perr_n}, {35'd0, exp_flag(pats[i], 1'b0)});
    end
  endtask

  task automatic t_odd();
    logic [W-1:0] pats [4];
    pats[0] = 36'h0;
    pats[1] = 36'h8_0402_0100;  // each lane: only parity bit set
    pats[2] = 36'h8_0402_0101;  // lane 0 now even
    pats[3] = 36'hF_FFFF_FFFF;
    idle(); odd_sel = 1'b1;
    foreach (pats[i]) begin
      @(negedge clk); bus_in = pats[i]; #1;
      chk("R2", "odd check", {35'd0, perr_n}, {35'd0, exp_flag(pats[i], 1'b1)});
    end
  endtask

  task automatic t_mask();
    @(negedge clk);
    odd_sel = 1'b0; bus_in = 36'h0_0000_0001;  // lane 0 fails even
    cs_n = 1'b0; xfer_en = 1'b1; wr_sel = 1'b0; mbox_sel = 1'b1; gen_en = 1'b1;
    #1 chk("R3", "masked flag", {35'd0, perr_n}, 36'd1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cs_n = 1'b0; xfer_en = 1'b1; wr_sel = 1'b0; mbox_sel = 1'b1; gen_en = 1'b1;
      case (k)
        0: cs_n = 1'b1;
        1: xfer_en = 1'b0;
        2: wr_sel = 1'b1;
        3: mbox_sel = 1'b0;
        default: gen_en = 1'b0;
      endcase
      #1 chk("R4", $sformatf("unmasked flag case %0d", k), {35'd0, perr_n}, 36'd0);
    end
    idle();
  endtask

  task automatic t_fifo_read();
    logic [W-1:0] raw;
    raw = 36'h1_2345_6789;
    @(negedge clk);
    cs_n = 1'b0; xfer_en = 1'b1; wr_sel = 1'b0; mbox_sel = 1'b0;
    gen_en = 1'b0; odd_sel = 1'b0; fifo_rd_data = raw;
    @(posedge clk); #1 idle();
    @(negedge clk);
    chk("R5", "raw fifo load", fifo_out, raw);
    chk("R10", "port_out shows fifo", port_out, raw);
    raw = 36'hA_5A5A_5A5A;
    cs_n = 1'b0; xfer_en = 1'b1; gen_en = 1'b1; odd_sel = 1'b1; fifo_rd_data = raw;
    @(posedge clk); #1 idle(); odd_sel = 1'b0;  // changed after the edge
    @(negedge clk);
    chk("R5", "generated odd fifo load", fifo_out, exp_gen(raw, 1'b1));
    raw = 36'h0_FF00_FF01;
    cs_n = 1'b0; xfer_en = 1'b1; gen_en = 1'b1; odd_sel = 1'b0; fifo_rd_data = raw;
    @(posedge clk); #1 idle();
    @(negedge clk);
    chk("R5", "generated even fifo load", fifo_out, exp_gen(raw, 1'b0));
  endtask

  task automatic t_fifo_hold();
    logic [W-1:0] held;
    @(negedge clk);
    held = fifo_out;
    idle(); fifo_rd_data = 36'h7_7777_7777;
    @(negedge clk);
    chk("R6", "hold when idle", fifo_out, held);
    cs_n = 1'b0; xfer_en = 1'b1; wr_sel = 1'b1; mbox_sel = 1'b0;
    @(negedge clk);
    chk("R6", "hold on write", fifo_out, held);
    wr_sel = 1'b0; mbox_sel = 1'b1;
    @(negedge clk);
    chk("R6", "hold on mailbox read", fifo_out, held);
    idle();
  endtask

  task automatic t_mbox();
    logic [W-1:0] m;
    m = 36'h3_C0FF_EE11;
    @(negedge clk);
    mbox_data = m; mbox_sel = 1'b1; gen_en = 1'b0; #1;
    chk("R7", "mailbox raw", mbox_out, m);
    chk("R10", "port_out shows mailbox", port_out, m);
    gen_en = 1'b1; odd_sel = 1'b1; #1;
    chk("R7", "mailbox odd gen", mbox_out, exp_gen(m, 1'b1));
    odd_sel = 1'b0; #1;
    chk("R7", "mailbox even gen", mbox_out, exp_gen(m, 1'b0));
    gen_en = 1'b0; #1;
    chk("R7", "mailbox unchanged after gen", mbox_out, m);
    idle();
  endtask

  task automatic t_store();
    logic [W-1:0] w;
    w = 36'hF_0000_0001;  // deliberately bad parity
    @(negedge clk);
    bus_in = w; cs_n = 1'b0; xfer_en = 1'b1; wr_sel = 1'b1; gen_en = 1'b1; odd_sel = 1'b1; #1;
    chk("R8", "store_en on write", {35'd0, store_en}, 36'd1);
    chk("R8", "store data unchanged", store_data, w);
    wr_sel = 1'b0; #1;
    chk("R8", "store_en low on read", {35'd0, store_en}, 36'd0);
    idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R1-R10 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_even();
    t_odd();
    t_mask();
    t_fifo_read();
    t_fifo_hold();
    t_mbox();
    t_store();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule